// File: doc/BRIEF.md
# Barrier and Eureka Synchronization Unit

A per-node array of synchronization units that the local processor reaches through single-cycle memory-mapped loads and stores. Each unit runs one of two kinds of group event. A barrier finishes only when every participant has arrived. A eureka finishes as soon as any one participant has signalled. The processor arms a unit and signals with stores. It polls the unit's state with loads. A load that finds the unit complete also hands the unit back to idle, so the next barrier or eureka can use it, possibly with a different group of participants.

Toward the network the block talks to a combining network interface through two simple ports. An outgoing message port carries arrive and eureka messages tagged with the unit index. An incoming broadcast port delivers "all arrived" and "eureka seen" events for a given unit. Counting participants and combining their messages is the network's job. Each unit only reacts to the final broadcast.

Top module: `bsu_array`

## Requirements
- R1: The block holds NUNITS (default 32) units. An operation, a read or a broadcast addressed to one unit leaves every other unit's state and error bit unchanged.
- R2: Unit state encoding is 00 idle, 01 barrier pending, 10 eureka pending, 11 complete. Request address bit 0 selects the register: 0 is the control/state register and 1 is the status register. The address bits above bit 0 give the unit index. A state-register read returns {0, state}.
- R3: A store of opcode 01 (arrive) to the control register of an idle unit moves it to barrier pending. In the cycle after the store it emits exactly one message with tx_kind 0 and tx_unit equal to the unit index.
- R4: An all-arrived broadcast for a barrier-pending unit moves it to complete. The same broadcast has no effect on a unit in any other state.
- R5: A store of opcode 10 (arm eureka) to an idle unit moves it to eureka pending and emits no message.
- R6: A store of opcode 11 (eureka signal) to a eureka-pending unit moves it to complete and emits one message with tx_kind 1 in the next cycle. In any other state the store is ignored and sends nothing.
- R7: A eureka broadcast moves a eureka-pending unit to complete. It has no effect on an idle unit.
- R8: A state-register read of a complete unit returns 11 and leaves the unit idle. Status-register reads have no side effect.
- R9: An arrive store to a unit that is already pending (01 or 10) is ignored and sends nothing, but sets the unit's sticky error bit. The error bit is read as bit 2 of the status register ({err, state}). It survives later state changes and is cleared only by a store of opcode 00.
- R10: Every read produces rsp_valid and rsp_rdata in the cycle after the request. Stores to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load/store request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | UNIT_W+1 | {unit index, register select} |
| req_wdata | input | 2 | Store opcode |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 3 | Load data |
| tx_valid | output | 1 | Outgoing message valid |
| tx_kind | output | 1 | 0 = arrive, 1 = eureka |
| tx_unit | output | UNIT_W | Unit index of outgoing message |
| rx_all_valid | input | 1 | All-arrived broadcast |
| rx_eureka_valid | input | 1 | Eureka broadcast |
| rx_unit | input | UNIT_W | Unit index of broadcast |

## Verification
A unit stuck in the wrong state shows up on the very next load of that unit's state or status register. It also shows one cycle after a store whose message is missing, extra or carries the wrong index or kind. A lost or spurious error bit is visible on the next status read. A unit that a neighbour's traffic disturbed is caught by reading the untouched unit right after the other unit has completed. A read that fails to free a complete unit is exposed by a second read, which still returns 11 where 00 is due.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    // Unit state encoding, visible to software through loads
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BPEND = 2'b01,
        ST_EPEND = 2'b10,
        ST_DONE  = 2'b11
    } unit_state_e;

    // Store opcodes to the control register
    typedef enum logic [1:0] {
        OP_CLRERR = 2'b00,
        OP_ARRIVE = 2'b01,
        OP_ARM    = 2'b10,
        OP_SIGNAL = 2'b11
    } unit_op_e;

    localparam int OP_W = 2;
    localparam int RD_W = 3;

    typedef struct packed {
        unit_state_e state;
        logic        err;
    } unit_regs_t;

    typedef struct packed {
        logic            valid;
        logic [RD_W-1:0] data;
    } rsp_t;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
    import bsu_pkg::*;
#(
    parameter int NUNITS = 32,
    parameter int UNIT_W = 5
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [UNIT_W:0]     req_addr,
    input  logic [OP_W-1:0]     req_wdata,
    output logic [NUNITS-1:0]   op_valid_vec,
    output logic [NUNITS-1:0]   rd_consume_vec,
    output unit_op_e            op,
    output logic [UNIT_W-1:0]   rd_unit,
    output logic                rd_status
);

    logic              sel_status;
    logic [UNIT_W-1:0] unit_idx;
    logic              ctl_write;
    logic              ctl_read;

    always_comb begin
        sel_status = req_addr[0];
        unit_idx   = req_addr[UNIT_W:1];
        ctl_write  = req_valid && req_write && !sel_status;
        ctl_read   = req_valid && !req_write && !sel_status;
        op         = unit_op_e'(req_wdata);
        rd_unit    = unit_idx;
        rd_status  = sel_status;
    end

    for (genvar g = 0; g < NUNITS; g++) begin : g_sel
        assign op_valid_vec[g]   = ctl_write && (unit_idx == UNIT_W'(g));
        assign rd_consume_vec[g] = ctl_read  && (unit_idx == UNIT_W'(g));
    end

endmodule

// File: rtl/bsu_unit.sv
module bsu_unit
    import bsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  unit_op_e    op,
    input  logic        rd_consume,
    input  logic        rx_all,
    input  logic        rx_eur,
    output logic [1:0]  state_o,
    output logic        err_o,
    output logic        send_arrive,
    output logic        send_eureka
);

    unit_regs_t  cur_q;
    unit_regs_t  nxt_d;
    unit_state_e mid_st;

    always_comb begin
        nxt_d       = cur_q;
        mid_st      = cur_q.state;
        send_arrive = 1'b0;
        send_eureka = 1'b0;

        // local store first
        if (op_valid) begin
            unique case (op)
                OP_CLRERR: nxt_d.err = 1'b0;
                OP_ARRIVE: begin
                    if (cur_q.state == ST_IDLE) begin
                        mid_st      = ST_BPEND;
                        send_arrive = 1'b1;
                    end else if (cur_q.state == ST_BPEND || cur_q.state == ST_EPEND) begin
                        nxt_d.err = 1'b1;
                    end
                end
                OP_ARM: begin
                    if (cur_q.state == ST_IDLE) mid_st = ST_EPEND;
                end
                OP_SIGNAL: begin
                    if (cur_q.state == ST_EPEND) begin
                        mid_st      = ST_DONE;
                        send_eureka = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // consuming read frees a complete unit
        if (rd_consume && cur_q.state == ST_DONE) mid_st = ST_IDLE;

        // network completion events apply after the local action
        if (rx_all && mid_st == ST_BPEND) mid_st = ST_DONE;
        if (rx_eur && mid_st == ST_EPEND) mid_st = ST_DONE;

        nxt_d.state = mid_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, err: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o = cur_q.state;
    assign err_o   = cur_q.err;

    p_arrive_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ARRIVE && cur_q.state == ST_IDLE && !rx_all)
        |=> (cur_q.state == ST_BPEND));

    p_all_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_BPEND && rx_all) |=> (cur_q.state == ST_DONE));

    p_arm_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ARM) |-> !send_arrive && !send_eureka);

    p_eureka_completes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_EPEND && rx_eur) |=> (cur_q.state == ST_DONE));

    p_read_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_consume && cur_q.state == ST_DONE) |=> (cur_q.state == ST_IDLE));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.err && !(op_valid && op == OP_CLRERR)) |=> cur_q.err);

endmodule

// File: rtl/bsu_netif.sv
module bsu_netif #(
    parameter int NUNITS = 32,
    parameter int UNIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUNITS-1:0] send_arrive,
    input  logic [NUNITS-1:0] send_eureka,
    output logic              tx_valid,
    output logic              tx_kind,
    output logic [UNIT_W-1:0] tx_unit,
    input  logic              rx_all_valid,
    input  logic              rx_eureka_valid,
    input  logic [UNIT_W-1:0] rx_unit,
    output logic [NUNITS-1:0] rx_all_vec,
    output logic [NUNITS-1:0] rx_eur_vec
);

    typedef struct packed {
        logic              valid;
        logic              kind;
        logic [UNIT_W-1:0] unit;
    } tx_t;

    tx_t tx_q;
    tx_t tx_d;

    always_comb begin
        tx_d = '0;
        for (int i = 0; i < NUNITS; i++) begin
            if (send_arrive[i] || send_eureka[i]) begin
                tx_d.valid = 1'b1;
                tx_d.kind  = send_eureka[i];
                tx_d.unit  = UNIT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_valid = tx_q.valid;
    assign tx_kind  = tx_q.kind;
    assign tx_unit  = tx_q.unit;

    for (genvar g = 0; g < NUNITS; g++) begin : g_rx
        assign rx_all_vec[g] = rx_all_valid    && (rx_unit == UNIT_W'(g));
        assign rx_eur_vec[g] = rx_eureka_valid && (rx_unit == UNIT_W'(g));
    end

    // one store per cycle can only start one message
    p_single_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(send_arrive | send_eureka));

    p_no_dual_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_arrive & send_eureka) == '0);

endmodule

// File: rtl/bsu_array.sv
module bsu_array
    import bsu_pkg::*;
#(
    parameter  int NUNITS = 32,
    localparam int UNIT_W = $clog2(NUNITS),
    localparam int ADDR_W = UNIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_wdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_rdata,
    output logic              tx_valid,
    output logic              tx_kind,
    output logic [UNIT_W-1:0] tx_unit,
    input  logic              rx_all_valid,
    input  logic              rx_eureka_valid,
    input  logic [UNIT_W-1:0] rx_unit
);

    logic [NUNITS-1:0] op_valid_vec;
    logic [NUNITS-1:0] rd_consume_vec;
    logic [NUNITS-1:0] send_arrive;
    logic [NUNITS-1:0] send_eureka;
    logic [NUNITS-1:0] rx_all_vec;
    logic [NUNITS-1:0] rx_eur_vec;
    unit_op_e          op;
    logic [UNIT_W-1:0] rd_unit;
    logic              rd_status;
    logic [1:0]        state_vec [NUNITS];
    logic              err_vec   [NUNITS];

    rsp_t rsp_q;
    rsp_t rsp_d;

    bsu_decode #(.NUNITS(NUNITS), .UNIT_W(UNIT_W)) i_decode (
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .op_valid_vec   (op_valid_vec),
        .rd_consume_vec (rd_consume_vec),
        .op             (op),
        .rd_unit        (rd_unit),
        .rd_status      (rd_status)
    );

    for (genvar g = 0; g < NUNITS; g++) begin : g_unit
        bsu_unit i_unit (
            .clk         (clk),
            .rst_n       (rst_n),
            .op_valid    (op_valid_vec[g]),
            .op          (op),
            .rd_consume  (rd_consume_vec[g]),
            .rx_all      (rx_all_vec[g]),
            .rx_eur      (rx_eur_vec[g]),
            .state_o     (state_vec[g]),
            .err_o       (err_vec[g]),
            .send_arrive (send_arrive[g]),
            .send_eureka (send_eureka[g])
        );
    end

    bsu_netif #(.NUNITS(NUNITS), .UNIT_W(UNIT_W)) i_netif (
        .clk             (clk),
        .rst_n           (rst_n),
        .send_arrive     (send_arrive),
        .send_eureka     (send_eureka),
        .tx_valid        (tx_valid),
        .tx_kind         (tx_kind),
        .tx_unit         (tx_unit),
        .rx_all_valid    (rx_all_valid),
        .rx_eureka_valid (rx_eureka_valid),
        .rx_unit         (rx_unit),
        .rx_all_vec      (rx_all_vec),
        .rx_eur_vec      (rx_eur_vec)
    );

    // read path: value before this cycle's update
    always_comb begin
        rsp_d = '0;
        if (req_valid && !req_write) begin
            rsp_d.valid = 1'b1;
            if (rd_status) rsp_d.data = {err_vec[rd_unit], state_vec[rd_unit]};
            else           rsp_d.data = {1'b0, state_vec[rd_unit]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_no_rsp_without_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    p_store_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

// File: tb/test_bsu_array.sv
`timescale 1ns/1ps
module test_bsu_array;

    localparam int UW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [UW:0]   req_addr = '0;
    logic [1:0]    req_wdata = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_rdata;
    logic          tx_valid;
    logic          tx_kind;
    logic [UW-1:0] tx_unit;
    logic          rx_all_valid = 1'b0;
    logic          rx_eureka_valid = 1'b0;
    logic [UW-1:0] rx_unit = '0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bsu_array #(.NUNITS(32)) i_bsu_array (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .rsp_valid       (rsp_valid),
        .rsp_rdata       (rsp_rdata),
        .tx_valid        (tx_valid),
        .tx_kind         (tx_kind),
        .tx_unit         (tx_unit),
        .rx_all_valid    (rx_all_valid),
        .rx_eureka_valid (rx_eureka_valid),
        .rx_unit         (rx_unit)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // store; returns just after the capturing edge, tx already registered
    task automatic wr(input int u, input bit sel, input logic [1:0] opc);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr  = {UW'(u), sel}; req_wdata = opc;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int u, input bit sel, output int data, output int vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = {UW'(u), sel};
        @(negedge clk);
        req_valid = 1'b0;
        data = int'(rsp_rdata);
        vld  = int'(rsp_valid);
    endtask

    task automatic bcast(input int u, input bit all, input bit eur);
        @(negedge clk);
        rx_all_valid = all; rx_eureka_valid = eur; rx_unit = UW'(u);
        @(negedge clk);
        rx_all_valid = 1'b0; rx_eureka_valid = 1'b0;
    endtask

    task automatic t_reset();
        int d, v;
        chk("R3 tx idle after reset", int'(tx_valid), 0);
        rd(0, 1'b0, d, v);
        chk("R2 reset state u0", d, 0);
        chk("R10 rsp_valid after read", v, 1);
        rd(5, 1'b1, d, v);
        chk("R9 reset status u5", d, 0);
    endtask

    task automatic t_barrier();
        int d, v;
        wr(3, 1'b0, 2'b01);
        chk("R3 arrive msg valid", int'(tx_valid), 1);
        chk("R3 arrive msg kind", int'(tx_kind), 0);
        chk("R3 arrive msg unit", int'(tx_unit), 3);
        @(negedge clk);
        chk("R3 single msg", int'(tx_valid), 0);
        rd(3, 1'b0, d, v);
        chk("R2 barrier pending", d, 1);
        bcast(3, 1'b1, 1'b0);
        rd(3, 1'b0, d, v);
        chk("R4 barrier complete", d, 3);
        rd(3, 1'b0, d, v);
        chk("R8 read frees unit", d, 0);
    endtask

    task automatic t_rx_ignored();
        int d, v;
        bcast(7, 1'b1, 1'b0);
        rd(7, 1'b1, d, v);
        chk("R4 all-arrived on idle ignored", d, 0);
        bcast(7, 1'b0, 1'b1);
        rd(7, 1'b1, d, v);
        chk("R7 eureka on idle ignored", d, 0);
    endtask

    task automatic t_eureka_local();
        int d, v;
        wr(31, 1'b0, 2'b10);
        chk("R5 arm sends nothing", int'(tx_valid), 0);
        rd(31, 1'b0, d, v);
        chk("R5 eureka pending", d, 2);
        wr(31, 1'b0, 2'b11);
        chk("R6 eureka msg valid", int'(tx_valid), 1);
        chk("R6 eureka msg kind", int'(tx_kind), 1);
        chk("R6 eureka msg unit", int'(tx_unit), 31);
        rd(31, 1'b1, d, v);
        chk("R8 status shows complete", d, 3);
        rd(31, 1'b1, d, v);
        chk("R8 status read no side effect", d, 3);
        rd(31, 1'b0, d, v);
        chk("R8 state read returns complete", d, 3);
        rd(31, 1'b0, d, v);
        chk("R8 unit idle after read", d, 0);
    endtask

    task automatic t_eureka_remote();
        int d, v;
        wr(0, 1'b0, 2'b10);
        bcast(0, 1'b0, 1'b1);
        rd(0, 1'b0, d, v);
        chk("R7 remote eureka completes", d, 3);
        rd(0, 1'b0, d, v);
        chk("R8 freed after remote eureka", d, 0);
    endtask

    task automatic t_signal_ignored();
        int d, v;
        wr(9, 1'b0, 2'b11);
        chk("R6 signal on idle sends nothing", int'(tx_valid), 0);
        rd(9, 1'b1, d, v);
        chk("R6 signal on idle no change", d, 0);
    endtask

    task automatic t_double_arrive();
        int d, v;
        wr(12, 1'b0, 2'b01);
        wr(12, 1'b0, 2'b01);
        chk("R9 repeated arrive sends nothing", int'(tx_valid), 0);
        rd(12, 1'b1, d, v);
        chk("R9 error set, still pending", d, 5);
        rd(13, 1'b1, d, v);
        chk("R1 neighbour untouched", d, 0);
        bcast(12, 1'b1, 1'b0);
        rd(12, 1'b1, d, v);
        chk("R9 error sticky across completion", d, 7);
        rd(12, 1'b0, d, v);
        chk("R8 consuming read", d, 3);
        rd(12, 1'b1, d, v);
        chk("R9 error kept after reuse", d, 4);
        wr(12, 1'b0, 2'b00);
        rd(12, 1'b1, d, v);
        chk("R9 clear opcode clears error", d, 0);
        wr(20, 1'b0, 2'b10);
        wr(20, 1'b0, 2'b01);
        rd(20, 1'b1, d, v);
        chk("R9 arrive on eureka pending", d, 6);
        wr(20, 1'b0, 2'b00);
        bcast(20, 1'b0, 1'b1);
        rd(20, 1'b0, d, v);
        chk("R7 eureka after error clear", d, 3);
    endtask

    task automatic t_status_write();
        int d, v;
        wr(4, 1'b1, 2'b01);
        chk("R10 status store sends nothing", int'(tx_valid), 0);
        rd(4, 1'b0, d, v);
        chk("R10 status store ignored", d, 0);
    endtask

    task automatic t_independent();
        int d, v;
        wr(1, 1'b0, 2'b01);
        wr(2, 1'b0, 2'b01);
        bcast(1, 1'b1, 1'b0);
        rd(2, 1'b0, d, v);
        chk("R1 other unit still pending", d, 1);
        rd(1, 1'b0, d, v);
        chk("R1 target unit complete", d, 3);
        bcast(2, 1'b1, 1'b0);
        rd(2, 1'b0, d, v);
        chk("R4 second unit complete", d, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_barrier();
        t_rx_ignored();
        t_eureka_local();
        t_eureka_remote();
        t_signal_ignored();
        t_double_arrive();
        t_status_write();
        t_independent();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule